// File: doc/BRIEF.md
# Chainable 8-bit ALU Slice with Condition Flags

This block is a purely combinational arithmetic and logic slice. It takes two operands, a single carry/fill bit and a 4-bit operation code. From these it produces a result word, a carry-out bit and three condition flags: zero, sign and signed overflow. It computes six operations: addition, subtraction, bitwise AND, bitwise XOR, and a one-place shift in each direction.

The carry input has two jobs. Arithmetic operations add it in as the carry. The shifts use it as the bit that enters the vacated position. The carry output likewise holds either the arithmetic carry or the bit that a shift pushes out. Because of this, a wider unit can be built by wiring the carry-out of one slice into the carry-in of the next. That wrapper is outside this block.

Internally, every candidate result is formed at the same time. A selector steered by the operation code then chooses the result and its carry and overflow bits. The block has no clock and no state, so the outputs follow the inputs through one combinational path.

Top module: `alu_slice`

## Requirements
- R1: Operation code 0000 (add) gives result = (B + A + carry_in) mod 256. carry_out is the carry from bit 7.
- R2: Operation code 0001 (subtract) gives result = (B + ~A + carry_in) mod 256, which equals B − A when carry_in = 1. carry_out is the carry from bit 7.
- R3: The overflow flag follows the adder operands for add and subtract. For add, it is 1 when A[7] equals B[7] and result[7] differs from them. For subtract, it is 1 when B[7] equals (~A)[7] and result[7] differs from B[7]. In all other cases it is 0.
- R4: Operation code 0010 gives result = A AND B, with carry_out = 0 and overflow = 0.
- R5: Operation code 0011 gives result = A XOR B, with carry_out = 0 and overflow = 0.
- R6: Operation code 0100 (shift right by one) gives result = {carry_in, A[7:1]}, carry_out = A[0] and overflow = 0.
- R7: Operation code 0101 (shift left by one) gives result = {A[6:0], carry_in}, carry_out = A[7] and overflow = 0.
- R8: For every operation code, zero_flag is 1 exactly when result is 0, and sign_flag equals result[7].
- R9: Operation codes 0110 through 1111 give result = 0, carry_out = 0, overflow = 0, zero_flag = 1 and sign_flag = 0.
- R10: carry_in has no effect on the outputs for AND and XOR. B has no effect on the outputs for either shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 8 | First operand. It is the subtracted operand, and the only operand for the shifts. |
| opd_b | input | 8 | Second operand. |
| carry_in | input | 1 | Arithmetic carry-in; also the fill bit for the shifts. |
| op_code | input | 4 | Selects the operation. |
| result | output | 8 | Selected result word. |
| carry_out | output | 1 | Arithmetic carry, or the bit shifted out. |
| zero_flag | output | 1 | High when result is zero. |
| sign_flag | output | 1 | Copy of result[7]. |
| ovf_flag | output | 1 | Signed overflow for add and subtract; low otherwise. |

## Verification
The bench targets signed overflow at both boundaries: 0x7F + 0x01, 0x80 + 0x80, and subtracting 1 from 0x80. A design that tested the raw A operand instead of its complement during subtraction would raise the flag on the wrong subtract cases. Subtracting equal operands with carry_in = 1 must give a zero result together with carry_out = 1. A design that inverted the carry would report a borrow there. The bench toggles carry_in under the logic operations and B under the shifts, which exposes any fill or carry path that leaks into those outputs. It also sweeps all ten unused codes; a selector that decoded only the low three bits would alias codes 1000 through 1101 onto real operations.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    parameter int SLICE_W = 8;
    parameter int OPC_W   = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3,
        OP_SHR = 4'd4,
        OP_SHL = 4'd5
    } alu_op_e;

endpackage

// File: rtl/alu_add_path.sv
module alu_add_path #(
    parameter int W = 8
) (
    input  logic [W-1:0] addend_b,
    input  logic [W-1:0] addend_a,
    input  logic         invert_a,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] a_eff;
    logic [W:0]   wide;

    always_comb begin
        a_eff = invert_a ? ~addend_a : addend_a;
        wide  = {1'b0, addend_b} + {1'b0, a_eff} + {{W{1'b0}}, cin};
        sum   = wide[W-1:0];
        cout  = wide[W];
        ovf   = (addend_b[W-1] == a_eff[W-1]) && (wide[W-1] != addend_b[W-1]);
    end

endmodule

// File: rtl/alu_bit_units.sv
module alu_bit_units #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         fill,
    output logic [W-1:0] and_f,
    output logic [W-1:0] xor_f,
    output logic [W-1:0] shr_f,
    output logic         shr_out,
    output logic [W-1:0] shl_f,
    output logic         shl_out
);
    always_comb begin
        and_f   = a & b;
        xor_f   = a ^ b;
        shr_f   = {fill, a[W-1:1]};
        shr_out = a[0];
        shl_f   = {a[W-2:0], fill};
        shl_out = a[W-1];
    end

endmodule

// File: rtl/alu_out_select.sv
module alu_out_select
    import alu_slice_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] add_f,
    input  logic         add_c,
    input  logic         add_v,
    input  logic [W-1:0] sub_f,
    input  logic         sub_c,
    input  logic         sub_v,
    input  logic [W-1:0] and_f,
    input  logic [W-1:0] xor_f,
    input  logic [W-1:0] shr_f,
    input  logic         shr_c,
    input  logic [W-1:0] shl_f,
    input  logic         shl_c,
    output logic [W-1:0] sel_f,
    output logic         sel_c,
    output logic         sel_v
);
    always_comb begin
        sel_f = '0;
        sel_c = 1'b0;
        sel_v = 1'b0;
        unique case (op)
            OP_ADD: begin sel_f = add_f; sel_c = add_c; sel_v = add_v; end
            OP_SUB: begin sel_f = sub_f; sel_c = sub_c; sel_v = sub_v; end
            OP_AND: sel_f = and_f;
            OP_XOR: sel_f = xor_f;
            OP_SHR: begin sel_f = shr_f; sel_c = shr_c; end
            OP_SHL: begin sel_f = shl_f; sel_c = shl_c; end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
    parameter int W = 8
) (
    input  logic [W-1:0] f,
    output logic         zf,
    output logic         sf
);
    always_comb begin
        zf = (f == '0);
        sf = f[W-1];
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_slice_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0]     opd_a,
    input  logic [W-1:0]     opd_b,
    input  logic             carry_in,
    input  logic [OPC_W-1:0] op_code,
    output logic [W-1:0]     result,
    output logic             carry_out,
    output logic             zero_flag,
    output logic             sign_flag,
    output logic             ovf_flag
);
    localparam int NUM_ARITH = 2;

    logic [W-1:0] ar_f [NUM_ARITH];
    logic         ar_c [NUM_ARITH];
    logic         ar_v [NUM_ARITH];

    logic [W-1:0] and_f, xor_f, shr_f, shl_f;
    logic         shr_c, shl_c;
    alu_op_e      op;

    assign op = alu_op_e'(op_code);

    // index 0 adds A, index 1 adds the complement of A
    for (genvar g = 0; g < NUM_ARITH; g++) begin : g_arith
        alu_add_path #(.W(W)) u_add (
            .addend_b (opd_b),
            .addend_a (opd_a),
            .invert_a (1'(g)),
            .cin      (carry_in),
            .sum      (ar_f[g]),
            .cout     (ar_c[g]),
            .ovf      (ar_v[g])
        );
    end

    alu_bit_units #(.W(W)) u_bits (
        .a       (opd_a),
        .b       (opd_b),
        .fill    (carry_in),
        .and_f   (and_f),
        .xor_f   (xor_f),
        .shr_f   (shr_f),
        .shr_out (shr_c),
        .shl_f   (shl_f),
        .shl_out (shl_c)
    );

    alu_out_select #(.W(W)) u_sel (
        .op    (op),
        .add_f (ar_f[0]),
        .add_c (ar_c[0]),
        .add_v (ar_v[0]),
        .sub_f (ar_f[1]),
        .sub_c (ar_c[1]),
        .sub_v (ar_v[1]),
        .and_f (and_f),
        .xor_f (xor_f),
        .shr_f (shr_f),
        .shr_c (shr_c),
        .shl_f (shl_f),
        .shl_c (shl_c),
        .sel_f (result),
        .sel_c (carry_out),
        .sel_v (ovf_flag)
    );

    alu_flag_gen #(.W(W)) u_flags (
        .f  (result),
        .zf (zero_flag),
        .sf (sign_flag)
    );

    always_comb begin
        if (op_code > OPC_W'(OP_SHL)) begin
            a_r9_unused_quiet: assert (result == '0 && !carry_out && !ovf_flag && zero_flag);
        end
        if (op == OP_AND || op == OP_XOR || op == OP_SHR || op == OP_SHL) begin
            a_r4_logic_no_overflow: assert (!ovf_flag);
        end
        if (op == OP_SHR) begin
            a_r6_shr_fill: assert (result[W-1] == carry_in && carry_out == opd_a[0]);
        end
        if (op == OP_SHL) begin
            a_r7_shl_fill: assert (result[0] == carry_in && carry_out == opd_a[W-1]);
        end
        if (op == OP_ADD && opd_a == '0 && !carry_in) begin
            a_r1_add_identity: assert (result == opd_b && !carry_out && !ovf_flag);
        end
        a_r8_zero_not_negative: assert (!(zero_flag && sign_flag));
    end

endmodule

// File: tb/alu_slice_test.sv
`timescale 1ns/1ps
module alu_slice_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a = '0, b = '0;
    logic       cin = 1'b0;
    logic [3:0] opc = '0;
    logic [7:0] result;
    logic       carry_out, zero_flag, sign_flag, ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    alu_slice uut (
        .opd_a     (a),
        .opd_b     (b),
        .carry_in  (cin),
        .op_code   (opc),
        .result    (result),
        .carry_out (carry_out),
        .zero_flag (zero_flag),
        .sign_flag (sign_flag),
        .ovf_flag  (ovf_flag)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h op=%0d a=%0h b=%0h cin=%0b",
                     req, what, act, exp, opc, a, b, cin);
        end
    endtask

    function automatic string req_of(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(int av, int bv, int cv, int op, string tag);
        int f, co, of, s, na;
        string rq;
        @(posedge clk);
        a = 8'(av); b = 8'(bv); cin = 1'(cv); opc = 4'(op);
        f = 0; co = 0; of = 0;
        case (op)
            0: begin
                s = bv + av + cv; f = s % 256; co = s / 256;
                of = ((av >= 128) == (bv >= 128)) && ((f >= 128) != (av >= 128));
            end
            1: begin
                na = 255 - av; s = bv + na + cv; f = s % 256; co = s / 256;
                of = ((bv >= 128) == (na >= 128)) && ((f >= 128) != (bv >= 128));
            end
            2: f = av & bv;
            3: f = av ^ bv;
            4: begin f = cv * 128 + av / 2; co = av % 2; end
            5: begin f = (av * 2) % 256 + cv; co = av / 128; end
            default: ;
        endcase
        @(negedge clk);
        rq = (tag != "") ? tag : req_of(op);
        check(rq, "result", int'(result), f);
        check(rq, "carry_out", int'(carry_out), co);
        check((op < 2) ? "R3" : rq, "ovf_flag", int'(ovf_flag), of);
        check("R8", "zero_flag", int'(zero_flag), int'(f == 0));
        check("R8", "sign_flag", int'(sign_flag), f / 128);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        int va, vb, vc;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // settled state with all-zero inputs (add of zeros)
        check("R8", "idle zero_flag", int'(zero_flag), 1);
        check("R1", "idle result", int'(result), 0);

        // R1/R3 add boundaries
        apply(8'h01, 8'h7F, 0, 0, "R3");
        apply(8'h80, 8'h80, 0, 0, "R3");
        apply(8'h01, 8'hFF, 0, 0, "R1");
        apply(8'h00, 8'hFF, 1, 0, "R1");
        apply(8'hC0, 8'hC0, 0, 0, "R3");
        // R2/R3 subtract boundaries
        apply(8'h01, 8'h80, 1, 1, "R3");
        apply(8'h55, 8'h55, 1, 1, "R2");
        apply(8'h02, 8'h01, 1, 1, "R2");
        apply(8'hFF, 8'h7F, 1, 1, "R3");
        apply(8'h10, 8'h20, 0, 1, "R2");
        // shifts with both fill values
        apply(8'h81, 8'h00, 1, 4, "R6");
        apply(8'h81, 8'h00, 0, 4, "R6");
        apply(8'h81, 8'h00, 1, 5, "R7");
        apply(8'h01, 8'h00, 0, 4, "R6");
        apply(8'h80, 8'h00, 0, 5, "R7");
        // R10: carry_in under logic, B under shifts
        for (int k = 0; k < 2; k++) begin
            apply(8'hF0, 8'h3C, k, 2, "R10");
            apply(8'hF0, 8'hF0, k, 3, "R10");
            apply(8'h5A, k ? 8'hFF : 8'h00, 1, 4, "R10");
            apply(8'h5A, k ? 8'hFF : 8'h00, 0, 5, "R10");
        end
        // R9 unused codes with busy operands
        for (int op = 6; op < 16; op++) begin
            apply(8'hFF, 8'hFF, 1, op, "R9");
            apply(8'h80, 8'h7F, 0, op, "R9");
        end
        // pseudo-random sweep of every code
        for (int op = 0; op < 16; op++) begin
            for (int n = 0; n < 300; n++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                va = int'(lfsr[7:0]);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                vb = int'(lfsr[15:8]);
                vc = int'(lfsr[3]);
                apply(va, vb, vc, op, "");
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule